// File: doc/BRIEF.md
# Backlog-Driven Voltage-Frequency Level Controller

This controller picks the operating level of a checker core that replays work already done by a partner core. The partner sends ahead two kinds of data: branch outcomes and instruction results. Each kind waits in its own queue until the checker core uses it. A growing backlog in either queue shows that the checker core is falling behind and needs a faster level. Nearly empty queues show that it has spare speed, so its level can drop to save energy.

The occupancy of both queues is examined only when the update-interval tick arrives. Each occupancy is compared with its own programmable pair of low and high limits, so there are four limits in total. If any queue is above its high limit, the controller moves the level index up by one step. If that does not apply and any queue is below its low limit, the index moves down by one step. An increase always takes priority over a decrease. The index stays within the table of operating points.

Each step produces a one-cycle change-request strobe for the regulator and clock logic. After a step, the controller can hold a busy window of `SWITCH_LAT` cycles while the supply settles. Ticks that arrive during this window are dropped. The regulator and the clock generator are outside this block.

Top module: `backlog_dvfs_ctrl`

## Requirements
- R1: During and directly after reset, `level` equals `NUM_LEVELS-1` (the fastest operating point), and `changeReq` and `busy` are both 0.
- R2: On a tick with `busy` low, if `brOcc > brHi` or `resOcc > resHi`, `level` rises by exactly one. The new value is visible at the clock edge that samples the tick.
- R3: On a tick with `busy` low and no raise condition, if `brOcc < brLo` or `resOcc < resLo`, `level` falls by exactly one at the same edge.
- R4: When one queue is over its high limit and the other is under its low limit, the level rises.
- R5: In cycles without a tick, `level` does not change and `changeReq` stays 0, whatever the occupancies are.
- R6: At level `NUM_LEVELS-1`, a raise condition leaves `level` unchanged and produces no `changeReq`. A decrease is not applied either, because the raise condition takes priority.
- R7: At level 0, a lower condition leaves `level` unchanged and produces no `changeReq`.
- R8: `changeReq` is high for exactly the one cycle in which `level` shows its new value, and at no other time.
- R9: After each level change, `busy` is 1 for exactly `SWITCH_LAT` cycles. Ticks during those cycles are ignored.
- R10: An occupancy equal to a limit does not trigger a step. Only strictly greater than a high limit or strictly less than a low limit counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Update-interval pulse; occupancies are evaluated only in cycles where it is high |
| brOcc | input | OCC_W | Branch-outcome queue occupancy |
| resOcc | input | OCC_W | Result queue occupancy |
| brLo | input | OCC_W | Branch queue low limit |
| brHi | input | OCC_W | Branch queue high limit |
| resLo | input | OCC_W | Result queue low limit |
| resHi | input | OCC_W | Result queue high limit |
| level | output | LVL_W | Current operating-point index, 0 = slowest |
| changeReq | output | 1 | One-cycle pulse when `level` takes a new value |
| busy | output | 1 | Switch settling window in progress |

## Verification
The bench first holds both occupancies far outside their limits with no tick, which separates interval gating from threshold decoding. It then walks the level from the top to the bottom using only the branch queue, which shows the step size, both saturation ends and the busy window. Occupancies placed exactly on each limit separate strict comparison from inclusive comparison. A mixed pattern, with one queue starved and the other flooded, shows the priority. Back-to-back ticks right after a change show whether ticks in the settling window are dropped or deferred.

// File: rtl/backlog_dvfs_pkg.sv
package backlog_dvfs_pkg;
  // Step command passed from the decision logic to the level register
  typedef struct packed {
    logic incr;
    logic decr;
  } stepCmd_t;
endpackage

// File: rtl/backlog_dvfs_decide.sv
module backlog_dvfs_decide
  import backlog_dvfs_pkg::*;
#(
  parameter int OCC_W      = 10,
  parameter int SWITCH_LAT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [OCC_W-1:0] brOcc,
  input  logic [OCC_W-1:0] resOcc,
  input  logic [OCC_W-1:0] brLo,
  input  logic [OCC_W-1:0] brHi,
  input  logic [OCC_W-1:0] resLo,
  input  logic [OCC_W-1:0] resHi,
  input  logic             atTop,
  input  logic             atBot,
  output stepCmd_t         cmd,
  output logic             busy
);
  localparam int LAT_W = (SWITCH_LAT > 0) ? $clog2(SWITCH_LAT + 1) : 1;

  logic wantUp, wantDown, evalNow;

  // strict comparisons: equality with a limit is neutral
  always_comb begin
    wantUp   = (brOcc > brHi) || (resOcc > resHi);
    wantDown = (brOcc < brLo) || (resOcc < resLo);
    evalNow  = tick && !busy;
    cmd.incr = evalNow && wantUp && !atTop;
    cmd.decr = evalNow && !wantUp && wantDown && !atBot;
  end

  generate
    if (SWITCH_LAT > 0) begin : g_settle
      logic [LAT_W-1:0] cntQ;
      always_ff @(posedge clk) begin
        if (!rstN)                      cntQ <= '0;
        else if (cmd.incr || cmd.decr)  cntQ <= LAT_W'(SWITCH_LAT);
        else if (cntQ != '0)            cntQ <= cntQ - LAT_W'(1);
      end
      assign busy = (cntQ != '0);

      // R9: a step opens the settling window on the next cycle
      a_r9_busy_after_step: assert property (@(posedge clk) disable iff (!rstN)
        (cmd.incr || cmd.decr) |=> busy);
      // R9: the window only closes by counting, never jumps back open without a step
      a_r9_no_reopen: assert property (@(posedge clk) disable iff (!rstN)
        (!busy && !(cmd.incr || cmd.decr)) |=> !busy);
    end else begin : g_nosettle
      assign busy = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/backlog_dvfs_level.sv
module backlog_dvfs_level
  import backlog_dvfs_pkg::*;
#(
  parameter int NUM_LEVELS = 8,
  parameter int LVL_W      = $clog2(NUM_LEVELS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  stepCmd_t         cmd,
  output logic [LVL_W-1:0] level,
  output logic             changeReq,
  output logic             atTop,
  output logic             atBot
);
  localparam logic [LVL_W-1:0] MAX_LVL = LVL_W'(NUM_LEVELS - 1);

  logic [LVL_W-1:0] levelQ;
  logic             reqQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ <= MAX_LVL;
      reqQ   <= 1'b0;
    end else begin
      if (cmd.incr)      levelQ <= levelQ + LVL_W'(1);
      else if (cmd.decr) levelQ <= levelQ - LVL_W'(1);
      reqQ <= cmd.incr || cmd.decr;
    end
  end

  assign level     = levelQ;
  assign changeReq = reqQ;
  assign atTop     = (levelQ == MAX_LVL);
  assign atBot     = (levelQ == '0);

  // R5: without a step command the index holds
  a_r5_hold_without_step: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.incr || cmd.decr) |=> $stable(levelQ));
  // R8: the request strobe marks exactly the cycles where the index moved
  a_r8_req_marks_change: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (reqQ == (levelQ != $past(levelQ))));
  // R2/R3: any move is a single step
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rstN)
    reqQ |-> ((levelQ == $past(levelQ) + LVL_W'(1)) || ($past(levelQ) == levelQ + LVL_W'(1))));
  // R6/R7: the index never leaves the table
  a_r6_in_table: assert property (@(posedge clk) disable iff (!rstN)
    levelQ <= MAX_LVL);
endmodule

// File: rtl/backlog_dvfs_ctrl.sv
module backlog_dvfs_ctrl
  import backlog_dvfs_pkg::*;
#(
  parameter int OCC_W      = 10,
  parameter int NUM_LEVELS = 8,
  parameter int SWITCH_LAT = 4,
  localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [OCC_W-1:0] brOcc,
  input  logic [OCC_W-1:0] resOcc,
  input  logic [OCC_W-1:0] brLo,
  input  logic [OCC_W-1:0] brHi,
  input  logic [OCC_W-1:0] resLo,
  input  logic [OCC_W-1:0] resHi,
  output logic [LVL_W-1:0] level,
  output logic             changeReq,
  output logic             busy
);
  stepCmd_t stepCmd;
  logic     atTop, atBot;

  backlog_dvfs_decide #(.OCC_W(OCC_W), .SWITCH_LAT(SWITCH_LAT)) u_decide (
    .clk(clk), .rstN(rstN), .tick(tick),
    .brOcc(brOcc), .resOcc(resOcc),
    .brLo(brLo), .brHi(brHi), .resLo(resLo), .resHi(resHi),
    .atTop(atTop), .atBot(atBot),
    .cmd(stepCmd), .busy(busy)
  );

  backlog_dvfs_level #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_level (
    .clk(clk), .rstN(rstN), .cmd(stepCmd),
    .level(level), .changeReq(changeReq),
    .atTop(atTop), .atBot(atBot)
  );
endmodule

// File: tb/backlog_dvfs_ctrl_tb.sv
module backlog_dvfs_ctrl_tb;
  localparam int OCC_W = 10;
  localparam int NL    = 8;
  localparam int LAT   = 4;
  localparam int LW    = $clog2(NL);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             tick = 1'b0;
  logic [OCC_W-1:0] brOcc = '0, resOcc = '0;
  logic [OCC_W-1:0] brLo = 10'd4, brHi = 10'd20, resLo = 10'd8, resHi = 10'd40;
  logic [LW-1:0]    level;
  logic             changeReq, busy;

  int    total = 0, bad = 0;
  bit    en = 1'b0, done = 1'b0;
  string curReq = "R1";
  int    mLvl = 0, mBusy = 0, mReq = 0;

  always #4 clk = ~clk;

  backlog_dvfs_ctrl #(.OCC_W(OCC_W), .NUM_LEVELS(NL), .SWITCH_LAT(LAT)) u_dut (
    .clk(clk), .rstN(rstN), .tick(tick),
    .brOcc(brOcc), .resOcc(resOcc),
    .brLo(brLo), .brHi(brHi), .resLo(resLo), .resHi(resHi),
    .level(level), .changeReq(changeReq), .busy(busy)
  );

  task automatic chk(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", curReq, what, act, exp);
    end
  endtask

  // behavioural reference, one update per clock edge
  always @(posedge clk) begin
    if (!rstN) begin
      mLvl = NL - 1; mBusy = 0; mReq = 0;
    end else begin
      mReq = 0;
      if (tick && mBusy == 0) begin
        if (int'(brOcc) > int'(brHi) || int'(resOcc) > int'(resHi)) begin
          if (mLvl < NL - 1) begin mLvl++; mReq = 1; mBusy = LAT; end
        end else if (int'(brOcc) < int'(brLo) || int'(resOcc) < int'(resLo)) begin
          if (mLvl > 0) begin mLvl--; mReq = 1; mBusy = LAT; end
        end
      end else if (mBusy > 0) begin
        mBusy--;
      end
    end
  end

  always @(posedge clk) begin
    #2;
    if (en && !done) begin
      chk("level", int'(level), mLvl);
      chk("changeReq", int'(changeReq), mReq);
      chk("busy", int'(busy), (mBusy != 0) ? 1 : 0);
    end
  end

  task automatic pulseTick(int b, int r);
    @(negedge clk);
    brOcc = OCC_W'(b); resOcc = OCC_W'(r); tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset values
    curReq = "R1";
    repeat (2) @(posedge clk);
    en = 1'b1;
    idle(2);
    rstN = 1'b1;
    idle(2);

    // R5: occupancies far outside the limits but no tick
    curReq = "R5";
    brOcc = 10'd900; resOcc = 10'd0;
    idle(6);

    // R6: at the top a raise does nothing, and lowering is not applied
    curReq = "R6";
    pulseTick(100, 0);
    idle(3);
    chk("R6 level at top", int'(level), NL - 1);

    // R3 then R7: walk down on the branch queue alone, then saturate at 0
    for (int i = 0; i < NL + 1; i++) begin
      curReq = (i < NL - 1) ? "R3" : "R7";
      pulseTick(2, 20);
      idle(LAT + 1);
    end
    chk("R7 level at bottom", int'(level), 0);

    // R10: occupancies exactly on each limit cause no step
    curReq = "R10";
    pulseTick(20, 40);
    idle(2);
    pulseTick(4, 8);
    idle(2);
    chk("R10 level unchanged", int'(level), 0);

    // R2: result queue over its high limit raises
    curReq = "R2";
    pulseTick(10, 41);
    idle(LAT + 1);
    chk("R2 level raised", int'(level), 1);

    // R4: one queue starved, the other flooded: raise wins
    curReq = "R4";
    pulseTick(1, 50);
    idle(LAT + 1);
    chk("R4 level raised", int'(level), 2);

    // R9: ticks right after a change fall inside the window and are dropped
    curReq = "R9";
    pulseTick(30, 20);
    pulseTick(30, 20);
    pulseTick(0, 0);
    idle(1);
    chk("R9 ticks ignored while settling", int'(level), 3);
    idle(LAT);

    // R8: strobe follows each change; checked every cycle by the reference
    curReq = "R8";
    pulseTick(0, 20);
    idle(1);
    pulseTick(0, 20);
    idle(LAT + 2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule